// File: doc/BRIEF.md
# Single-Outstanding Address-Routed Bus Switch

This block sits between one TL-UL host and several TL-UL devices. It compares the address of each A-channel request against a table of device windows. It passes the request on to the one device whose window holds the address, and it steers that device's D-channel response back to the host. The default build has two windows. Device 0 is a 1 KB data memory at 0x0000_0000. Device 1 is a 4 KB register window at 0x4000_0000. Any address outside both windows is unmapped. The switch answers an unmapped request itself with an error response, and no device sees it.

The switch tracks exactly one transaction at a time. When it accepts a request it records the target index, the request opcode, the source tag and the size. The host-side ready stays low until the response handshake completes. The D channel is selected with the recorded index. Requests are single beat. There is no arbitration, no reordering and no burst support.

Top module: `busw_switch`

## Requirements
- R1: A request whose address lies in [0x0000_0000, 0x0000_03FF] raises only dev_a_valid_o[0]. A request whose address lies in [0x4000_0000, 0x4000_0FFF] raises only dev_a_valid_o[1]. At most one dev_a_valid_o bit is ever high.
- R2: The opcode, size, source, address, mask and data of a request appear unchanged on the shared device A-channel fields while the request is offered.
- R3: A request to an unmapped address raises no dev_a_valid_o bit and is accepted at once. In the next cycle the host sees host_d_valid_o=1 with host_d_error_o=1 and data 0.
- R4: After a request is accepted, host_a_ready_o stays 0 and no device is offered a request until the D handshake (host_d_valid_o and host_d_ready_i both high) completes. While idle, host_a_ready_o follows the addressed device's ready.
- R5: The response comes from the device selected at acceptance, with its data and error bit. The d_valid of any other device is ignored and gets no ready.
- R6: Get (opcode 4) is answered with AccessAckData (opcode 1). PutFullData (0) and PutPartialData (1) are answered with AccessAck (opcode 0). Error responses follow the same rule.
- R7: host_d_source_o and host_d_size_o carry the source and size of the request being answered.
- R8: After reset no host response is pending and no device request is raised.
- R9: dev_d_ready_o is high only toward the selected device, and only while host_d_ready_i is high. A response held by host back-pressure keeps its data and source stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_a_valid_i | input | 1 | Host request valid |
| host_a_ready_o | output | 1 | Switch can take a request |
| host_a_opcode_i | input | 3 | Request opcode |
| host_a_size_i | input | SZW | Request size (log2 bytes) |
| host_a_source_i | input | SRCW | Request source tag |
| host_a_address_i | input | AW | Request address |
| host_a_mask_i | input | DW/8 | Byte lane mask |
| host_a_data_i | input | DW | Write data |
| host_d_valid_o | output | 1 | Response valid |
| host_d_ready_i | input | 1 | Host takes the response |
| host_d_opcode_o | output | 3 | Response opcode |
| host_d_size_o | output | SZW | Echoed size |
| host_d_source_o | output | SRCW | Echoed source |
| host_d_data_o | output | DW | Read data |
| host_d_error_o | output | 1 | Response error |
| dev_a_valid_o | output | NDEV | Per-device request valid |
| dev_a_ready_i | input | NDEV | Per-device request ready |
| dev_a_opcode_o | output | 3 | Shared request opcode |
| dev_a_size_o | output | SZW | Shared request size |
| dev_a_source_o | output | SRCW | Shared request source |
| dev_a_address_o | output | AW | Shared request address |
| dev_a_mask_o | output | DW/8 | Shared byte mask |
| dev_a_data_o | output | DW | Shared write data |
| dev_d_valid_i | input | NDEV | Per-device response valid |
| dev_d_ready_o | output | NDEV | Per-device response ready |
| dev_d_data_i | input | NDEV*DW | Packed per-device read data |
| dev_d_error_i | input | NDEV | Per-device response error |

## Verification
The bench builds the switch with its defaults: NDEV=2, 32-bit address and data, and the 1 KB and 4 KB windows. The device models answer after different latencies, one cycle and three cycles, so the recorded index decides which D channel is used. The two windows and the gap between them let the bench reach the last word of each window and the first unmapped address past each one. A device that holds off its A-ready, a stalling host D-ready and a stray d_valid from the unselected device exercise back-pressure and response isolation.

// File: rtl/busw_pkg.sv
package busw_pkg;
  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_PUT_PART = 3'd1;
  localparam logic [2:0] OP_GET      = 3'd4;
  localparam logic [2:0] RSP_ACK      = 3'd0;
  localparam logic [2:0] RSP_ACK_DATA = 3'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_FWD, ST_ERR} sw_state_e;

  // response opcode for a given request opcode
  function automatic logic [2:0] rsp_opcode(input logic [2:0] req_op);
    return (req_op == OP_GET) ? RSP_ACK_DATA : RSP_ACK;
  endfunction
endpackage

// File: rtl/busw_decode.sv
module busw_decode #(
  parameter int AW   = 32,
  parameter int NDEV = 2,
  parameter int IDXW = 1,
  parameter logic [NDEV*AW-1:0] DEV_BASE = '0,
  parameter logic [NDEV*8-1:0]  DEV_SPAN_LOG2 = '0
) (
  input  logic [AW-1:0]   addr_i,
  output logic [NDEV-1:0] hit_o,
  output logic            miss_o,
  output logic [IDXW-1:0] idx_o
);
  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] base,
                                     input logic [7:0] lg);
    logic [AW-1:0] keep;
    keep = {AW{1'b1}} << lg;
    return (a & keep) == (base & keep);
  endfunction

  for (genvar g = 0; g < NDEV; g++) begin : g_win
    assign hit_o[g] = in_window(addr_i, DEV_BASE[g*AW +: AW], DEV_SPAN_LOG2[g*8 +: 8]);
  end

  assign miss_o = ~|hit_o;

  always_comb begin
    idx_o = '0;
    for (int k = NDEV - 1; k >= 0; k--) begin
      if (hit_o[k]) idx_o = IDXW'(k);
    end
  end
endmodule

// File: rtl/busw_track.sv
module busw_track
  import busw_pkg::*;
#(
  parameter int IDXW = 1,
  parameter int SRCW = 8,
  parameter int SZW  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            a_fire_i,
  input  logic            a_miss_i,
  input  logic [IDXW-1:0] a_idx_i,
  input  logic [2:0]      a_opcode_i,
  input  logic [SRCW-1:0] a_source_i,
  input  logic [SZW-1:0]  a_size_i,
  input  logic            d_fire_i,
  output logic            idle_o,
  output logic            fwd_o,
  output logic            err_o,
  output logic [IDXW-1:0] idx_q_o,
  output logic [2:0]      op_q_o,
  output logic [SRCW-1:0] src_q_o,
  output logic [SZW-1:0]  size_q_o
);
  sw_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q_o  <= '0;
      op_q_o   <= '0;
      src_q_o  <= '0;
      size_q_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (a_fire_i) begin
          state_q  <= a_miss_i ? ST_ERR : ST_FWD;
          idx_q_o  <= a_idx_i;
          op_q_o   <= a_opcode_i;
          src_q_o  <= a_source_i;
          size_q_o <= a_size_i;
        end
        ST_FWD, ST_ERR: if (d_fire_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign fwd_o  = (state_q == ST_FWD);
  assign err_o  = (state_q == ST_ERR);

  // R4
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_fire_i |=> idle_o);
  // R4
  accept_leaves_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_fire_i |=> !idle_o);
endmodule

// File: rtl/busw_rsp_mux.sv
module busw_rsp_mux #(
  parameter int NDEV = 2,
  parameter int DW   = 32,
  parameter int IDXW = 1
) (
  input  logic [NDEV-1:0]    dev_d_valid_i,
  input  logic [NDEV*DW-1:0] dev_d_data_i,
  input  logic [NDEV-1:0]    dev_d_error_i,
  output logic [NDEV-1:0]    dev_d_ready_o,
  input  logic               fwd_i,
  input  logic               err_i,
  input  logic [IDXW-1:0]    idx_i,
  input  logic               host_d_ready_i,
  output logic               host_d_valid_o,
  output logic [DW-1:0]      host_d_data_o,
  output logic               host_d_error_o
);
  always_comb begin
    host_d_valid_o = 1'b0;
    host_d_data_o  = '0;
    host_d_error_o = 1'b0;
    if (err_i) begin
      host_d_valid_o = 1'b1;
      host_d_error_o = 1'b1;
    end else if (fwd_i) begin
      for (int k = 0; k < NDEV; k++) begin
        if (idx_i == IDXW'(k)) begin
          host_d_valid_o = dev_d_valid_i[k];
          host_d_data_o  = dev_d_data_i[k*DW +: DW];
          host_d_error_o = dev_d_error_i[k];
        end
      end
    end
  end

  for (genvar g = 0; g < NDEV; g++) begin : g_rdy
    assign dev_d_ready_o[g] = fwd_i && (idx_i == IDXW'(g)) && host_d_ready_i;
  end
endmodule

// File: rtl/busw_switch.sv
module busw_switch
  import busw_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SRCW = 8,
  parameter int SZW  = 2,
  parameter int NDEV = 2,
  parameter logic [NDEV*AW-1:0] DEV_BASE      = {32'h4000_0000, 32'h0000_0000},
  parameter logic [NDEV*8-1:0]  DEV_SPAN_LOG2 = {8'd12, 8'd10}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_a_valid_i,
  output logic               host_a_ready_o,
  input  logic [2:0]         host_a_opcode_i,
  input  logic [SZW-1:0]     host_a_size_i,
  input  logic [SRCW-1:0]    host_a_source_i,
  input  logic [AW-1:0]      host_a_address_i,
  input  logic [DW/8-1:0]    host_a_mask_i,
  input  logic [DW-1:0]      host_a_data_i,
  output logic               host_d_valid_o,
  input  logic               host_d_ready_i,
  output logic [2:0]         host_d_opcode_o,
  output logic [SZW-1:0]     host_d_size_o,
  output logic [SRCW-1:0]    host_d_source_o,
  output logic [DW-1:0]      host_d_data_o,
  output logic               host_d_error_o,
  output logic [NDEV-1:0]    dev_a_valid_o,
  input  logic [NDEV-1:0]    dev_a_ready_i,
  output logic [2:0]         dev_a_opcode_o,
  output logic [SZW-1:0]     dev_a_size_o,
  output logic [SRCW-1:0]    dev_a_source_o,
  output logic [AW-1:0]      dev_a_address_o,
  output logic [DW/8-1:0]    dev_a_mask_o,
  output logic [DW-1:0]      dev_a_data_o,
  input  logic [NDEV-1:0]    dev_d_valid_i,
  output logic [NDEV-1:0]    dev_d_ready_o,
  input  logic [NDEV*DW-1:0] dev_d_data_i,
  input  logic [NDEV-1:0]    dev_d_error_i
);
  localparam int IDXW = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic [NDEV-1:0] a_hit;
  logic            a_miss;
  logic [IDXW-1:0] a_idx;
  logic            a_dev_ready;
  logic            a_fire;
  logic            d_fire;
  logic            idle, fwd, err;
  logic [IDXW-1:0] idx_q;
  logic [2:0]      op_q;
  logic [SRCW-1:0] src_q;
  logic [SZW-1:0]  size_q;

  busw_decode #(
    .AW(AW), .NDEV(NDEV), .IDXW(IDXW),
    .DEV_BASE(DEV_BASE), .DEV_SPAN_LOG2(DEV_SPAN_LOG2)
  ) u_decode (
    .addr_i (host_a_address_i),
    .hit_o  (a_hit),
    .miss_o (a_miss),
    .idx_o  (a_idx)
  );

  assign a_dev_ready    = |(a_hit & dev_a_ready_i);
  assign host_a_ready_o = idle && (a_miss || a_dev_ready);
  assign a_fire         = host_a_valid_i && host_a_ready_o;
  assign dev_a_valid_o  = {NDEV{host_a_valid_i && idle}} & a_hit;

  assign dev_a_opcode_o  = host_a_opcode_i;
  assign dev_a_size_o    = host_a_size_i;
  assign dev_a_source_o  = host_a_source_i;
  assign dev_a_address_o = host_a_address_i;
  assign dev_a_mask_o    = host_a_mask_i;
  assign dev_a_data_o    = host_a_data_i;

  busw_track #(.IDXW(IDXW), .SRCW(SRCW), .SZW(SZW)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_fire_i   (a_fire),
    .a_miss_i   (a_miss),
    .a_idx_i    (a_idx),
    .a_opcode_i (host_a_opcode_i),
    .a_source_i (host_a_source_i),
    .a_size_i   (host_a_size_i),
    .d_fire_i   (d_fire),
    .idle_o     (idle),
    .fwd_o      (fwd),
    .err_o      (err),
    .idx_q_o    (idx_q),
    .op_q_o     (op_q),
    .src_q_o    (src_q),
    .size_q_o   (size_q)
  );

  busw_rsp_mux #(.NDEV(NDEV), .DW(DW), .IDXW(IDXW)) u_rsp (
    .dev_d_valid_i  (dev_d_valid_i),
    .dev_d_data_i   (dev_d_data_i),
    .dev_d_error_i  (dev_d_error_i),
    .dev_d_ready_o  (dev_d_ready_o),
    .fwd_i          (fwd),
    .err_i          (err),
    .idx_i          (idx_q),
    .host_d_ready_i (host_d_ready_i),
    .host_d_valid_o (host_d_valid_o),
    .host_d_data_o  (host_d_data_o),
    .host_d_error_o (host_d_error_o)
  );

  assign d_fire          = host_d_valid_o && host_d_ready_i;
  assign host_d_opcode_o = rsp_opcode(op_q);
  assign host_d_source_o = src_q;
  assign host_d_size_o   = size_q;

  // R1
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_a_valid_o));
  // R4
  accept_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_fire |=> !host_a_ready_o);
  // R4
  no_fwd_while_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_d_valid_o |-> (dev_a_valid_o == '0));
  // R3
  miss_err_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_fire && a_miss) |=> (host_d_valid_o && host_d_error_o));
  // R9
  rsp_ready_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_d_ready_o) && (!host_d_ready_i -> dev_d_ready_o == '0));
  // R7
  rsp_tag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_d_valid_o && !host_d_ready_i) |=> $stable(host_d_source_o) && $stable(host_d_size_o));
endmodule

// File: tb/busw_switch_tb.sv
module busw_switch_tb;
  localparam logic [2:0] PUTF = 3'd0, PUTP = 3'd1, GET = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_valid = 1'b0;
  logic        a_ready;
  logic [2:0]  a_op = '0;
  logic [1:0]  a_size = '0;
  logic [7:0]  a_src = '0;
  logic [31:0] a_addr = '0;
  logic [3:0]  a_mask = '0;
  logic [31:0] a_data = '0;
  logic        d_valid;
  logic        d_ready = 1'b1;
  logic [2:0]  d_op;
  logic [1:0]  d_size;
  logic [7:0]  d_src;
  logic [31:0] d_data;
  logic        d_err;
  logic [1:0]  dv_a_valid, dv_a_ready;
  logic [2:0]  dv_a_op;
  logic [1:0]  dv_a_size;
  logic [7:0]  dv_a_src;
  logic [31:0] dv_a_addr;
  logic [3:0]  dv_a_mask;
  logic [31:0] dv_a_data;
  logic [1:0]  dv_d_valid, dv_d_ready, dv_d_err;
  logic [63:0] dv_d_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit stall = 0, ghost1 = 0, hold1 = 0;
  int cyc = 0;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic        err;
    logic [7:0]  src;
    logic [1:0]  size;
  } exp_t;
  exp_t q[$];
  logic [31:0] ref_mem [2][1024];

  always #5 clk = ~clk;

  busw_switch u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_a_valid_i(a_valid), .host_a_ready_o(a_ready), .host_a_opcode_i(a_op),
    .host_a_size_i(a_size), .host_a_source_i(a_src), .host_a_address_i(a_addr),
    .host_a_mask_i(a_mask), .host_a_data_i(a_data),
    .host_d_valid_o(d_valid), .host_d_ready_i(d_ready), .host_d_opcode_o(d_op),
    .host_d_size_o(d_size), .host_d_source_o(d_src), .host_d_data_o(d_data),
    .host_d_error_o(d_err),
    .dev_a_valid_o(dv_a_valid), .dev_a_ready_i(dv_a_ready), .dev_a_opcode_o(dv_a_op),
    .dev_a_size_o(dv_a_size), .dev_a_source_o(dv_a_src), .dev_a_address_o(dv_a_addr),
    .dev_a_mask_o(dv_a_mask), .dev_a_data_o(dv_a_data),
    .dev_d_valid_i(dv_d_valid), .dev_d_ready_o(dv_d_ready), .dev_d_data_i(dv_d_data),
    .dev_d_error_i(dv_d_err)
  );

  function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                        input logic [3:0] m);
    logic [31:0] r = old_w;
    for (int b = 0; b < 4; b++) if (m[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // device models: dev0 latency 1, dev1 latency 3; dev1 word 1023 answers with error
  for (genvar g = 0; g < 2; g++) begin : g_dev
    logic [31:0] mem [1024];
    logic        pend = 0, mv = 0, merr = 0;
    logic [31:0] mdat = '0;
    int          cnt = 0;
    localparam int LAT = (g == 0) ? 1 : 3;
    assign dv_a_ready[g] = !pend && !(g == 1 && hold1);
    assign dv_d_valid[g] = mv || (g == 1 && ghost1);
    assign dv_d_data[g*32 +: 32] = mv ? mdat : 32'hDEAD_BEEF;
    assign dv_d_err[g] = mv && merr;
    initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      forever begin
        @(posedge clk);
        if (dv_a_valid[g] && dv_a_ready[g]) begin
          logic [9:0] wi;
          wi = (g == 0) ? {2'b00, dv_a_addr[9:2]} : dv_a_addr[11:2];
          pend <= 1'b1;
          cnt  <= LAT;
          if (g == 1 && wi == 10'd1023) begin
            merr <= 1'b1; mdat <= '0;
          end else begin
            merr <= 1'b0;
            mdat <= (dv_a_op == GET) ? mem[wi] : 32'h0;
            if (dv_a_op != GET) mem[wi] <= merge(mem[wi], dv_a_data, dv_a_mask);
          end
        end else if (pend && !mv) begin
          if (cnt == 0) mv <= 1'b1; else cnt <= cnt - 1;
        end else if (mv && dv_d_ready[g]) begin
          mv <= 1'b0; pend <= 1'b0;
        end
      end
    end
  end

  // driver: offers one request, checks routing at acceptance, pushes the expectation
  task automatic txn(input logic [2:0] op, input logic [31:0] addr, input logic [31:0] data,
                     input logic [3:0] mask, input logic [7:0] src, input logic [1:0] size,
                     input int dev);
    exp_t e;
    @(negedge clk);
    a_op = op; a_addr = addr; a_data = data; a_mask = mask; a_src = src; a_size = size;
    a_valid = 1'b1;
    #1;
    while (!a_ready) begin
      @(negedge clk); #1;
    end
    if (dev < 0) check(dv_a_valid == 2'b00, "R3", "unmapped dev_a_valid", {30'd0, dv_a_valid}, 0);
    else check(dv_a_valid == (2'b01 << dev), "R1", "dev_a_valid select",
               {30'd0, dv_a_valid}, {30'd0, 2'b01 << dev});
    check(dv_a_addr == addr && dv_a_data == data && dv_a_mask == mask &&
          dv_a_op == op && dv_a_src == src && dv_a_size == size, "R2", "A fields",
          dv_a_addr, addr);
    e.op = (op == GET) ? 3'd1 : 3'd0;
    e.src = src; e.size = size; e.err = 1'b0; e.data = '0;
    if (dev < 0) e.err = 1'b1;
    else begin
      logic [9:0] wi;
      wi = (dev == 0) ? {2'b00, addr[9:2]} : addr[11:2];
      if (dev == 1 && wi == 10'd1023) e.err = 1'b1;
      else if (op == GET) e.data = ref_mem[dev][wi];
      else ref_mem[dev][wi] = merge(ref_mem[dev][wi], data, mask);
    end
    q.push_back(e);
    @(negedge clk);
    a_valid = 1'b0;
    #1;
    check(a_ready == 1'b0, "R4", "a_ready after accept", {31'd0, a_ready}, 0);
    if (dev < 0)
      check(d_valid && d_err && d_data == 0, "R3", "error response next cycle",
            {d_valid, d_err, 30'd0}, 32'hC000_0000);
  endtask

  // monitor / scoreboard and host D-ready driver
  logic        held = 0;
  logic [31:0] held_data;
  logic [7:0]  held_src;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      d_ready = stall ? (cyc % 3 == 2) : 1'b1;
      #1;
      if (rst_n) begin
        if (held) begin
          check(d_valid && d_data == held_data && d_src == {held_src},
                "R9", "held response stable", d_data, held_data);
        end
        held = 0;
        if (ghost1 && !g_dev[1].pend)
          check(dv_d_ready[1] == 1'b0, "R5", "stray d_valid got ready", {31'd0, dv_d_ready[1]}, 0);
        if (!d_ready) check(dv_d_ready == 2'b00, "R9", "device ready without host ready",
                            {30'd0, dv_d_ready}, 0);
        if (d_valid && !d_ready) begin
          held = 1; held_data = d_data; held_src = d_src;
        end
        if (d_valid && d_ready) begin
          if (q.size() == 0) begin
            check(0, "R5", "unexpected response", {31'd0, d_valid}, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(d_op == e.op, "R6", "d_opcode", {29'd0, d_op}, {29'd0, e.op});
            check(d_src == e.src && d_size == e.size, "R7", "source/size echo",
                  {22'd0, d_size, d_src}, {22'd0, e.size, e.src});
            check(d_err == e.err, "R5", "d_error", {31'd0, d_err}, {31'd0, e.err});
            if (e.op == 3'd1 || e.err)
              check(d_data == e.data, "R5", "d_data", d_data, e.data);
          end
        end
      end
    end
  end

  task automatic drain();
    int n = 0;
    while ((q.size() != 0 || d_valid) && n < 200) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) for (int i = 0; i < 1024; i++) ref_mem[d][i] = '0;
    repeat (3) @(negedge clk);
    #1;
    // R8
    check(d_valid == 1'b0 && dv_a_valid == 2'b00, "R8", "reset state",
          {30'd0, d_valid, |dv_a_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // data memory writes and reads
    txn(PUTF, 32'h0000_0010, 32'hA5A5_1234, 4'hF, 8'd3, 2'd2, 0);
    txn(GET,  32'h0000_0010, 32'h0, 4'hF, 8'd4, 2'd2, 0);
    txn(PUTP, 32'h0000_0010, 32'h1122_3344, 4'b0011, 8'd5, 2'd1, 0);
    txn(GET,  32'h0000_0010, 32'h0, 4'hF, 8'd6, 2'd2, 0);
    // window boundaries
    txn(PUTF, 32'h0000_03FC, 32'hCAFE_0001, 4'hF, 8'd7, 2'd2, 0);
    txn(GET,  32'h0000_03FC, 32'h0, 4'hF, 8'd8, 2'd2, 0);
    txn(GET,  32'h0000_0400, 32'h0, 4'hF, 8'd9, 2'd2, -1);
    txn(PUTF, 32'h4000_0008, 32'h0BAD_F00D, 4'hF, 8'd10, 2'd2, 1);
    txn(GET,  32'h4000_0008, 32'h0, 4'hF, 8'd11, 2'd2, 1);
    txn(PUTF, 32'h4000_0FF8, 32'h7777_8888, 4'hF, 8'd12, 2'd2, 1);
    txn(GET,  32'h4000_0FF8, 32'h0, 4'hF, 8'd13, 2'd2, 1);
    txn(GET,  32'h4000_0FFC, 32'h0, 4'hF, 8'd14, 2'd2, 1);
    txn(PUTF, 32'h4000_1000, 32'h1, 4'hF, 8'd15, 2'd2, -1);
    txn(GET,  32'h8000_0000, 32'h0, 4'hF, 8'd16, 2'd0, -1);
    drain();
    // host back-pressure
    stall = 1;
    for (int i = 0; i < 6; i++) begin
      txn(PUTF, 32'h0000_0100 + 32'(i*4), 32'h1000_0000 + 32'(i), 4'hF, 8'(20 + i), 2'd2, i % 2 == 0 ? 0 : 0);
      txn(GET,  32'h4000_0100 + 32'(i*4), 32'h0, 4'hF, 8'(40 + i), 2'd2, 1);
      txn(GET,  32'h0000_0100 + 32'(i*4), 32'h0, 4'hF, 8'(60 + i), 2'd2, 0);
    end
    drain();
    stall = 0;
    // stray response from the unselected device
    ghost1 = 1;
    txn(GET, 32'h0000_0104, 32'h0, 4'hF, 8'd80, 2'd2, 0);
    txn(PUTF, 32'h0000_0200, 32'h5555_AAAA, 4'hF, 8'd81, 2'd2, 0);
    txn(GET, 32'h0000_0200, 32'h0, 4'hF, 8'd82, 2'd2, 0);
    drain();
    ghost1 = 0;
    @(negedge clk);
    // device A-ready held low
    hold1 = 1;
    fork
      begin repeat (4) @(negedge clk); hold1 = 0; end
      txn(PUTF, 32'h4000_0040, 32'hFEED_0040, 4'hF, 8'd90, 2'd2, 1);
    join
    txn(GET, 32'h4000_0040, 32'h0, 4'hF, 8'd91, 2'd2, 1);
    drain();
    // mixed back-to-back
    for (int i = 0; i < 20; i++) begin
      int sel = i % 3;
      logic [31:0] ad;
      ad = (sel == 0) ? 32'h0000_0300 + 32'((i % 4) * 4)
         : (sel == 1) ? 32'h4000_0300 + 32'((i % 4) * 4) : 32'h2000_0000;
      txn((i % 2 == 0) ? PUTP : GET, ad, 32'h3000_0000 + 32'(i), 4'b1100, 8'(100 + i), 2'd2,
          (sel == 2) ? -1 : sel);
    end
    drain();
    check(q.size() == 0, "R5", "all responses returned", 32'(q.size()), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule